// File: doc/BRIEF.md
# Search-Mode Envelope Qualifier and Tape Speed Meter

This block sits behind the envelope slicer of an auxiliary tape track while the deck winds fast with the head on the tape. It takes the already sliced envelope bit and a one-cycle tick that marks each auxiliary block. From these it raises a label flag when the envelope has stayed high for a long stretch and a blank-tape flag when it has stayed low for a long stretch. Both flags have hysteresis so short dropouts do not make them toggle.

The block also measures how long each envelope-high run lasts, counted in prescaled clock ticks. It reports the result as an 8-bit speed word for the control port: a 5-bit count, a 2-bit range exponent and an invalid flag. The range moves up or down by itself so that the count stays in a useful window. The reported speed is proportional to 2^range / count. Outside search mode all three flag outputs are held low, and all internal state is cleared so that every entry into search mode starts fresh.

Top module: `search_envelope_detector`

## Requirements
- R1: `op_mode` encodes normal 2'b00, test 2'b01, search 2'b10, off 2'b11. Outside search, `label_o`, `blank_o` and `env_o` are low in the same cycle. In search, `env_o` equals `env_in`.
- R2: `label_o` rises in the cycle after the RUN_BLOCKS-th (default 8) consecutive block tick that sampled `env_in` high. Once set, it stays high until RUN_BLOCKS consecutive ticks sample low, and then it falls in the cycle after that tick.
- R3: `blank_o` behaves in the same way with the polarities swapped, and it changes in the same cycle that `label_o` changes the other way. The two flags are never high together.
- R4: A single block tick that samples the opposite polarity restarts the run count. After it, a full RUN_BLOCKS ticks of the new polarity are needed before the flag changes.
- R5: The speed word `speed_o` is laid out as bit 7 = invalid (1 = not valid), bits 6:2 = count SC and bits 1:0 = range SR. Reset and entry into search set it to 8'h80.
- R6: For an envelope-high run of N cycles, SC = floor(N / (BASE_DIV * 2^(3-SR))), saturating at 31. The word is updated in the cycle after the first cycle in which `env_in` is sampled low.
- R7: After a measured run, SR rises by one if SC <= 1 and SR < 3, and falls by one if SC >= 18 and SR > 0. In either case the invalid bit is set. Otherwise the invalid bit is cleared and SR is kept.
- R8: A run that was already high when search mode was entered is not measured, and the speed word stays unchanged when that run ends.
- R9: Entering search mode clears both flags and returns the speed word to 8'h80, whatever state was reached before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 2 | Operating mode (search = 2'b10) |
| env_in | input | 1 | Sliced auxiliary-track envelope bit |
| blk_tick | input | 1 | One-cycle pulse per auxiliary block |
| label_o | output | 1 | Label-present flag |
| blank_o | output | 1 | Blank (unrecorded) tape flag |
| env_o | output | 1 | Envelope passed through in search mode |
| speed_o | output | 8 | Invalid flag, count SC, range SR |

## Verification
The bench builds the block with BASE_DIV = 2 and the default RUN_BLOCKS = 8. With these values, runs of a few hundred cycles cover counts from 0 up to saturation at 31 in every range. Directed runs walk SR from 0 up to 3 and back, and hit both range limits, where no shift may happen. Random run lengths then exercise the up and down shifts and the invalid-bit handling against a bench model of R6 and R7.

// File: rtl/srch_det_pkg.sv
// Shared types for the search-mode envelope qualifier.
// Assumes a 2-bit operating mode code in which only search enables the block.
package srch_det_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SEARCH = 2'b10,
        MODE_OFF    = 2'b11
    } op_mode_e;

    localparam int SC_W = 5;
    localparam int SR_W = 2;

    typedef struct packed {
        logic            invalid;
        logic [SC_W-1:0] sc;
        logic [SR_W-1:0] sr;
    } speed_word_t;

endpackage

// File: rtl/env_run_qualifier.sv
// Counts consecutive auxiliary blocks of equal envelope polarity and sets the
// label or blank flag once a run reaches RUN_BLOCKS ticks (with hysteresis).
// Assumes blk_tick is a one-cycle pulse. While active is low, all state is cleared.
module env_run_qualifier #(
    parameter int RUN_BLOCKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic blk_tick,
    input  logic env,
    output logic label_q,
    output logic blank_q
);
    localparam int CW = $clog2(RUN_BLOCKS + 1);
    localparam logic [CW-1:0] THR = CW'(RUN_BLOCKS);

    logic [CW-1:0] hi_cnt, lo_cnt, hi_next, lo_next;

    // Saturating next values of both run counters.
    always_comb begin
        hi_next = (hi_cnt == THR) ? hi_cnt : hi_cnt + 1'b1;
        lo_next = (lo_cnt == THR) ? lo_cnt : lo_cnt + 1'b1;
    end

    // Advance the run counters on each block tick and update the flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            label_q <= 1'b0;
            blank_q <= 1'b0;
        end else if (blk_tick) begin
            if (env) begin
                hi_cnt <= hi_next;
                lo_cnt <= '0;
                if (hi_next == THR) begin
                    label_q <= 1'b1;
                    blank_q <= 1'b0;
                end
            end else begin
                lo_cnt <= lo_next;
                hi_cnt <= '0;
                if (lo_next == THR) begin
                    blank_q <= 1'b1;
                    label_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/run_tick_prescaler.sv
// Produces measurement ticks during an envelope-high run. The divide ratio is
// BASE_DIV * 2^(max range - sr), so a higher range gives finer ticks.
// Assumes BASE_DIV >= 2. The first high cycle (start) counts as one cycle.
module run_tick_prescaler #(
    parameter int BASE_DIV = 64,
    parameter int SR_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            hold,
    input  logic [SR_W-1:0] sr,
    output logic            tick
);
    localparam int SR_TOP  = (1 << SR_W) - 1;
    localparam int DIV_MAX = BASE_DIV << SR_TOP;
    localparam int PW      = $clog2(DIV_MAX + 1);

    logic [PW-1:0]   pre_cnt, div_lim;
    logic [SR_W-1:0] shamt;

    // Divide ratio for the current range.
    always_comb begin
        shamt   = SR_W'(SR_TOP) - sr;
        div_lim = PW'(BASE_DIV) << shamt;
        tick    = hold && (pre_cnt == div_lim - 1'b1);
    end

    // Cycle counter within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (start) begin
            pre_cnt <= PW'(1);
        end else if (hold) begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/speed_range_tracker.sv
// Accumulates ticks over a complete envelope-high run and captures the count
// when the run ends. It then moves the range toward the useful count window and
// sets or clears the invalid bit. While active is low, state returns to invalid, SC 0, SR 0.
module speed_range_tracker
    import srch_det_pkg::*;
#(
    parameter int UP_LIMIT   = 1,
    parameter int DOWN_LIMIT = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            start,
    input  logic            fall,
    input  logic            tick,
    output logic [SR_W-1:0] sr,
    output speed_word_t     word
);
    localparam logic [SC_W-1:0] ACC_MAX = '1;
    localparam logic [SR_W-1:0] SR_MAX  = '1;

    logic [SC_W-1:0] acc, sc;
    logic            clean, invalid;

    // Count ticks of the current run and evaluate the run when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            acc     <= '0;
            clean   <= 1'b0;
            sc      <= '0;
            sr      <= '0;
            invalid <= 1'b1;
        end else begin
            if (start) begin
                acc   <= '0;
                clean <= 1'b1;
            end else if (tick && acc != ACC_MAX) begin
                acc <= acc + 1'b1;
            end
            if (fall) begin
                clean <= 1'b0;
                if (clean) begin
                    sc <= acc;
                    if (acc < SC_W'(UP_LIMIT + 1) && sr != SR_MAX) begin
                        sr      <= sr + 1'b1;
                        invalid <= 1'b1;
                    end else if (acc >= SC_W'(DOWN_LIMIT) && sr != '0) begin
                        sr      <= sr - 1'b1;
                        invalid <= 1'b1;
                    end else begin
                        invalid <= 1'b0;
                    end
                end
            end
        end
    end

    // Assemble the speed word.
    always_comb begin
        word.invalid = invalid;
        word.sc      = sc;
        word.sr      = sr;
    end
endmodule

// File: rtl/search_envelope_detector.sv
// Top of the search-mode envelope qualifier: gates everything by the search
// mode and finds envelope run edges. It feeds the block-run qualifier and the speed meter.
// Assumes env_in and blk_tick are synchronous to clk.
module search_envelope_detector
    import srch_det_pkg::*;
#(
    parameter int RUN_BLOCKS = 8,
    parameter int BASE_DIV   = 64,
    parameter int UP_LIMIT   = 1,
    parameter int DOWN_LIMIT = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_mode,
    input  logic       env_in,
    input  logic       blk_tick,
    output logic       label_o,
    output logic       blank_o,
    output logic       env_o,
    output logic [7:0] speed_o
);
    logic            search, env_q, run_start, run_hold, run_end, tick;
    logic            label_q, blank_q;
    logic [SR_W-1:0] sr;
    speed_word_t     word;

    assign search = (op_mode_e'(op_mode) == MODE_SEARCH);

    // Previous envelope value. It is held high outside search so that a run already in progress is not taken as a start.
    always_ff @(posedge clk) begin
        if (!rst_n || !search) env_q <= 1'b1;
        else                   env_q <= env_in;
    end

    // Run edge strobes.
    always_comb begin
        run_start = search &&  env_in && !env_q;
        run_hold  = search &&  env_in &&  env_q;
        run_end   = search && !env_in &&  env_q;
    end

    env_run_qualifier #(.RUN_BLOCKS(RUN_BLOCKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .active(search), .blk_tick(blk_tick),
        .env(env_in), .label_q(label_q), .blank_q(blank_q)
    );

    run_tick_prescaler #(.BASE_DIV(BASE_DIV), .SR_W(SR_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .start(run_start), .hold(run_hold),
        .sr(sr), .tick(tick)
    );

    speed_range_tracker #(.UP_LIMIT(UP_LIMIT), .DOWN_LIMIT(DOWN_LIMIT)) u_spd (
        .clk(clk), .rst_n(rst_n), .active(search), .start(run_start),
        .fall(run_end), .tick(tick), .sr(sr), .word(word)
    );

    // Output gating by mode.
    always_comb begin
        label_o = label_q & search;
        blank_o = blank_q & search;
        env_o   = env_in  & search;
        speed_o = word;
    end
endmodule

// File: rtl/search_envelope_detector_props.sv
// Property checker for search_envelope_detector, attached through bind.
module search_envelope_detector_props (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_mode,
    input logic       env_in,
    input logic       blk_tick,
    input logic       label_o,
    input logic       blank_o,
    input logic       env_o,
    input logic [7:0] speed_o,
    input logic       run_end
);
    logic in_search;
    assign in_search = (op_mode == 2'b10);

    assert_quiet_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_search |-> (!label_o && !blank_o && !env_o));

    assert_label_after_high_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(label_o) |-> ($past(blk_tick) && $past(env_in)));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(label_o && blank_o));

    assert_word_moves_on_run_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_search && $past(in_search) && !$stable(speed_o)) |-> $past(run_end));

    assert_range_step_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_search && $past(in_search) && (speed_o[1:0] != $past(speed_o[1:0])))
        |-> (speed_o[7] && ((speed_o[1:0] == $past(speed_o[1:0]) + 2'd1) ||
                            (speed_o[1:0] == $past(speed_o[1:0]) - 2'd1))));

    assert_entry_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_search && !$past(in_search)) |-> (speed_o == 8'h80 && !label_o && !blank_o));
endmodule

bind search_envelope_detector search_envelope_detector_props u_props (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .env_in(env_in),
    .blk_tick(blk_tick), .label_o(label_o), .blank_o(blank_o),
    .env_o(env_o), .speed_o(speed_o), .run_end(run_end)
);

// File: tb/tb_search_envelope_detector.sv
module tb_search_envelope_detector;
    localparam int BASE_DIV   = 2;
    localparam int RUN_BLOCKS = 8;
    localparam logic [1:0] M_NORMAL = 2'b00, M_TEST = 2'b01, M_SEARCH = 2'b10, M_OFF = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_mode = M_SEARCH;
    logic       env_in = 1'b0;
    logic       blk_tick = 1'b0;
    logic       label_o, blank_o, env_o;
    logic [7:0] speed_o;

    int total = 0;
    int bad = 0;
    int m_sr = 0;

    always #5 clk = ~clk;

    search_envelope_detector #(.RUN_BLOCKS(RUN_BLOCKS), .BASE_DIV(BASE_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .env_in(env_in),
        .blk_tick(blk_tick), .label_o(label_o), .blank_o(blank_o),
        .env_o(env_o), .speed_o(speed_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic block(input logic e);
        env_in = e; blk_tick = 1'b1; step();
        blk_tick = 1'b0; step();
    endtask

    // Expected speed word for a clean run of n cycles (R6, R7); updates m_sr.
    function automatic logic [7:0] model_run(input int n);
        int div, sc;
        logic inv;
        div = BASE_DIV << (3 - m_sr);
        sc  = n / div;
        if (sc > 31) sc = 31;
        if (sc <= 1 && m_sr < 3) begin m_sr++; inv = 1'b1; end
        else if (sc >= 18 && m_sr > 0) begin m_sr--; inv = 1'b1; end
        else inv = 1'b0;
        return {inv, 5'(sc), 2'(m_sr)};
    endfunction

    task automatic run_check(input int n, input string req);
        logic [7:0] exp;
        exp = model_run(n);
        env_in = 1'b1;
        repeat (n) step();
        env_in = 1'b0;
        step();
        chk(req, speed_o, exp);
        step();
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R5 reset state
        chk("R5 reset word", speed_o, 8'h80);
        chk("R2 reset label", {7'd0, label_o}, 8'd0);
        chk("R3 reset blank", {7'd0, blank_o}, 8'd0);
        // R1 passthrough and gating
        env_in = 1'b1; #1;
        chk("R1 env passthrough", {7'd0, env_o}, 8'd1);
        op_mode = M_NORMAL; #1;
        chk("R1 env gated normal", {7'd0, env_o}, 8'd0);
        env_in = 1'b0; step();
        op_mode = M_SEARCH; step();

        // R2 label set after RUN_BLOCKS high ticks
        for (int i = 0; i < RUN_BLOCKS - 1; i++) block(1'b1);
        chk("R2 label not yet", {7'd0, label_o}, 8'd0);
        block(1'b1);
        chk("R2 label set", {7'd0, label_o}, 8'd1);
        // R2/R3 release and blank set
        for (int i = 0; i < RUN_BLOCKS - 1; i++) block(1'b0);
        chk("R2 label held", {7'd0, label_o}, 8'd1);
        chk("R3 blank not yet", {7'd0, blank_o}, 8'd0);
        block(1'b0);
        chk("R2 label released", {7'd0, label_o}, 8'd0);
        chk("R3 blank set", {7'd0, blank_o}, 8'd1);
        // R4 restart by one opposite tick
        for (int i = 0; i < RUN_BLOCKS - 1; i++) block(1'b1);
        block(1'b0);
        for (int i = 0; i < RUN_BLOCKS - 1; i++) block(1'b1);
        chk("R4 restart label", {7'd0, label_o}, 8'd0);
        chk("R4 restart blank", {7'd0, blank_o}, 8'd1);
        block(1'b1);
        chk("R4 label after full run", {7'd0, label_o}, 8'd1);
        chk("R3 blank cleared", {7'd0, blank_o}, 8'd0);
        // R1 gating in test mode, R9 clear on re-entry
        op_mode = M_TEST; #1;
        chk("R1 label gated test", {7'd0, label_o}, 8'd0);
        chk("R1 env gated test", {7'd0, env_o}, 8'd0);
        step();
        env_in = 1'b0;
        op_mode = M_SEARCH; step();
        chk("R9 label cleared", {7'd0, label_o}, 8'd0);
        chk("R9 word reset", speed_o, 8'h80);

        // R8 run already high at entry is ignored
        op_mode = M_OFF; env_in = 1'b1; step();
        op_mode = M_SEARCH;
        repeat (40) step();
        env_in = 1'b0; step();
        chk("R8 partial run ignored", speed_o, 8'h80);
        step();

        // Directed speed runs, m_sr = 0
        m_sr = 0;
        run_check(100, "R6 sc6 sr0");
        chk("R6 literal", speed_o, 8'h18);
        run_check(20, "R7 shift up");
        chk("R7 literal up", speed_o, 8'h85);
        run_check(600, "R7 shift down sat");
        chk("R7 literal down", speed_o, 8'hFC);
        run_check(600, "R6 saturate bottom range");
        chk("R6 literal sat", speed_o, 8'h7C);
        run_check(1, "R7 up to 1");
        run_check(1, "R7 up to 2");
        run_check(1, "R7 up to 3");
        chk("R7 literal sr3", speed_o, 8'h83);
        run_check(1, "R7 top range holds");
        chk("R7 literal top", speed_o, 8'h03);

        // Random runs
        for (int k = 0; k < 60; k++) begin
            run_check(1 + int'($urandom % 400), "R6 R7 random");
            repeat ($urandom % 4) step();
        end

        // R1 off mode gating at the end
        env_in = 1'b1;
        op_mode = M_OFF; #1;
        chk("R1 env gated off", {7'd0, env_o}, 8'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule